// File: doc/BRIEF.md
# Address-Masked Pin Data Register

This block holds the data value of an eight-pin general-purpose port and uses part of the bus address as a per-bit mask. Address bits [9:2] select which pins an access touches. A write changes only the selected bits of the stored value. A read returns only the selected bits and forces the rest to zero. Software can therefore set, clear or sample any subset of pins in one bus access, with no read-modify-write sequence and no race with other code that owns the other pins.

The block sits beside a direction register and a pin synchronizer, and both of those are external to it. When a pin is an output, a read returns the value last stored for that pin. When a pin is an input, a read returns the synchronized level seen on the pin. The stored value reaches the pin-drive output only on bits whose direction is output. Address bits [1:0] take no part in decoding. To reach pin n alone, software uses the byte offset 1 << (n+2) from the register base.

Top module: `masked_pin_data_reg`

## Requirements
- R1: On a clock edge where `bus_we` is 1, stored bit n takes `bus_wdata[n]` when `bus_addr[n+2]` is 1. The new value is visible from the next cycle.
- R2: On a write, stored bit n keeps its previous value when `bus_addr[n+2]` is 0.
- R3: `bus_rdata[n]` is 0 whenever `bus_addr[n+2]` is 0, whatever the stored or pin value.
- R4: With `pin_dir[n]` = 1 (output) and the mask bit set, `bus_rdata[n]` equals stored bit n.
- R5: With `pin_dir[n]` = 0 (input) and the mask bit set, `bus_rdata[n]` equals `pin_in[n]` in the same cycle, combinationally.
- R6: `pin_drive[n]` equals stored bit n when `pin_dir[n]` = 1 and is 0 when `pin_dir[n]` = 0.
- R7: Reset (active-low `rst_n`) clears every stored bit to 0.
- R8: `bus_addr[1:0]` has no effect on writes or reads.
- R9: A write at byte offset 1 << (n+2) changes only stored bit n.
- R10: With `bus_we` at 0, no stored bit changes, whatever the address and data.
- R11: A write to a pin that is currently an input still updates the stored bit. That value appears on `pin_drive` and in reads once the pin becomes an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | PINS+2 (10) | Word address; bits [PINS+1:2] are the per-pin mask |
| bus_wdata | input | PINS (8) | Write data |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| pin_dir | input | PINS (8) | Direction per pin, 1 = output |
| pin_in | input | PINS (8) | Synchronized pin levels |
| bus_rdata | output | PINS (8) | Masked read data, combinational |
| pin_drive | output | PINS (8) | Stored value gated by direction |

## Verification
A wrong stored bit is visible within one cycle of the write that caused it. It shows on `pin_drive` for output pins and in a read that selects the pin. A stored bit that is corrupted while the pin is an input stays hidden until the direction flips, so the bench writes to input pins and then turns them into outputs. A mask decode that is off by one bit position shows in the single-pin offset sweep as a neighbouring pin that changes, and in masked reads as a nonzero bit outside the mask.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
   // lowest address bit that carries the pin mask (word addressing)
   localparam int MASK_LSB = 2;

   // byte offset that selects only pin n
   function automatic int unsigned pin_offset(input int unsigned n);
      return 32'd1 << (n + MASK_LSB);
   endfunction
endpackage

// File: rtl/mdr_mask_decode.sv
module mdr_mask_decode #(
   parameter int PINS = 8,
   localparam int ADDR_W = PINS + mdr_pkg::MASK_LSB
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [PINS-1:0]   mask
);
   localparam int LSB = mdr_pkg::MASK_LSB;

   initial begin
      if (PINS < 1 || PINS > 30)
         $error("mdr_mask_decode: PINS must lie in 1..30");
   end

   assign mask = addr[ADDR_W-1:LSB];

   // byte-lane bits take no part in decoding
   logic unused_lane_bits;
   assign unused_lane_bits = ^addr[LSB-1:0];
endmodule

// File: rtl/mdr_bit_store.sv
module mdr_bit_store #(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PINS-1:0] mask,
   input  logic [PINS-1:0] wdata,
   output logic [PINS-1:0] q
);
   initial begin
      if (PINS < 1)
         $error("mdr_bit_store: PINS must be positive");
   end

   for (genvar i = 0; i < PINS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 1'b0;
         else if (we && mask[i])
            q[i] <= wdata[i];
      end

      a_r1_masked_update: assert property (@(posedge clk) disable iff (!rst_n)
         (we && mask[i]) |=> (q[i] == $past(wdata[i])));

      a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && mask[i]) |=> (q[i] == $past(q[i])));
   end

   a_r7_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (q == '0));
endmodule

// File: rtl/mdr_read_mux.sv
module mdr_read_mux #(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] mask,
   input  logic [PINS-1:0] q,
   input  logic [PINS-1:0] dir,
   input  logic [PINS-1:0] pin_in,
   output logic [PINS-1:0] rdata
);
   for (genvar i = 0; i < PINS; i++) begin : g_rd
      logic src;
      assign src      = dir[i] ? q[i] : pin_in[i];
      assign rdata[i] = mask[i] & src;
   end

   a_r3_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((rdata & ~mask) == '0));

   a_r4_output_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (((rdata ^ q) & mask & dir) == '0));

   a_r5_input_live: assert property (@(posedge clk) disable iff (!rst_n)
      (((rdata ^ pin_in) & mask & ~dir) == '0));
endmodule

// File: rtl/masked_pin_data_reg.sv
module masked_pin_data_reg #(
   parameter int PINS = 8,
   localparam int ADDR_W = PINS + mdr_pkg::MASK_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PINS-1:0]   bus_wdata,
   input  logic              bus_we,
   input  logic [PINS-1:0]   pin_dir,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   bus_rdata,
   output logic [PINS-1:0]   pin_drive
);
   initial begin
      if (PINS < 1 || PINS > 30)
         $error("masked_pin_data_reg: PINS must lie in 1..30");
   end

   logic [PINS-1:0] sel_mask;
   logic [PINS-1:0] stored;

   mdr_mask_decode #(.PINS(PINS)) u_dec (
      .addr (bus_addr),
      .mask (sel_mask)
   );

   mdr_bit_store #(.PINS(PINS)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .mask  (sel_mask),
      .wdata (bus_wdata),
      .q     (stored)
   );

   mdr_read_mux #(.PINS(PINS)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask   (sel_mask),
      .q      (stored),
      .dir    (pin_dir),
      .pin_in (pin_in),
      .rdata  (bus_rdata)
   );

   for (genvar i = 0; i < PINS; i++) begin : g_drv
      assign pin_drive[i] = pin_dir[i] & stored[i];
   end

   a_r6_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_drive & ~pin_dir) == '0));
endmodule

// File: tb/masked_pin_data_reg_test.sv
module masked_pin_data_reg_test;
   localparam int CLK_PERIOD = 10;
   localparam int PINS = 8;
   localparam int AW = PINS + 2;

   typedef struct {
      int         kind;   // 0 = read data, 1 = pin drive
      logic [7:0] exp;
      string      tag;
   } chk_t;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic          bus_we = 0;
   logic [7:0]    pin_dir = '0;
   logic [7:0]    pin_in = '0;
   logic [7:0]    bus_rdata;
   logic [7:0]    pin_drive;

   logic [7:0] model_q = '0;
   chk_t       sb[$];
   event       sample_ev;
   int         checks = 0;
   int         fails = 0;
   bit         done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   masked_pin_data_reg #(.PINS(PINS)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .pin_dir(pin_dir), .pin_in(pin_in),
      .bus_rdata(bus_rdata), .pin_drive(pin_drive)
   );

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(sample_ev);
         while (sb.size() > 0) begin
            chk_t c;
            logic [7:0] act;
            c = sb.pop_front();
            act = (c.kind == 0) ? bus_rdata : pin_drive;
            checks++;
            if (act !== c.exp) begin
               fails++;
               $display("FAIL %s: actual %02h expected %02h", c.tag, act, c.exp);
            end
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic we_v);
      logic [7:0] m;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = we_v;
      @(posedge clk);
      m = a[AW-1:2];
      if (we_v) model_q = (model_q & ~m) | (d & m);
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic expect_rd(input logic [AW-1:0] a, input string tag);
      chk_t c;
      logic [7:0] m;
      @(negedge clk);
      bus_addr = a;
      #1;
      m = a[AW-1:2];
      c.kind = 0;
      c.exp  = m & ((model_q & pin_dir) | (pin_in & ~pin_dir));
      c.tag  = tag;
      sb.push_back(c);
      -> sample_ev;
      #1;
   endtask

   task automatic expect_drive(input string tag);
      chk_t c;
      #1;
      c.kind = 1;
      c.exp  = model_q & pin_dir;
      c.tag  = tag;
      sb.push_back(c);
      -> sample_ev;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      pin_dir = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R7 reset state
      expect_rd(10'h3FC, "R7 reset read");
      expect_drive("R7 reset drive");

      // R1 R4 R6 full-mask write
      wr(10'h3FC, 8'hA5, 1);
      expect_rd(10'h3FC, "R1 R4 full write readback");
      expect_drive("R6 drive all outputs");

      // R2 partial mask: low nibble only
      wr(10'h03C, 8'h5A, 1);
      expect_rd(10'h3FC, "R2 upper nibble held");

      // R10 strobe low
      wr(10'h3FC, 8'h00, 0);
      expect_rd(10'h3FC, "R10 no write without strobe");

      // R3 masked read
      expect_rd(10'h3C0, "R3 low nibble masked out");
      expect_rd(10'h000, "R3 empty mask reads zero");

      // R8 byte-lane bits ignored
      wr(10'h3FF, 8'h00, 1);
      expect_rd(10'h3FE, "R8 lane bits ignored");
      wr(10'h001, 8'hFF, 1);
      expect_rd(10'h3FD, "R8 lane bits alone do not write");

      // R9 single-pin offsets
      for (int n = 0; n < PINS; n++) begin
         wr(AW'(mdr_pkg::pin_offset(n)), 8'hFF, 1);
         expect_rd(10'h3FC, $sformatf("R9 single pin %0d", n));
      end
      for (int n = 0; n < PINS; n += 2) begin
         wr(AW'(mdr_pkg::pin_offset(n)), 8'h00, 1);
      end
      expect_rd(10'h3FC, "R9 clear even pins");

      // R5 mixed directions, live inputs
      @(negedge clk);
      pin_dir = 8'h0F; pin_in = 8'h3C;
      expect_rd(10'h3FC, "R5 mixed direction read");
      expect_drive("R6 drive gated by direction");
      @(negedge clk);
      pin_in = 8'hC3;
      expect_rd(10'h3FC, "R5 input follows pin");

      // R11 write while input
      @(negedge clk);
      pin_dir = 8'h00;
      wr(10'h3FC, 8'h81, 1);
      expect_drive("R11 inputs drive zero");
      @(negedge clk);
      pin_dir = 8'hFF;
      expect_rd(10'h3FC, "R11 stored while input");
      expect_drive("R11 drive after direction flip");

      // R7 reset mid-run
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      model_q = '0;
      expect_rd(10'h3FC, "R7 reset clears");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule